// File: doc/BRIEF.md
# Challenge-Response Debug Access Gate

This block decides whether a chip's debug port may be used. Two fused mode bits and a separate kill bit choose one of three policies: debug always open, debug never open, or debug opened only after the host proves it knows a hidden 56-bit key. The block sits behind a reduced JTAG shift interface. The TAP controller supplies capture, shift and update strobes, a register select and TDI, and reads TDO back.

In the authenticated policy the host first captures and shifts out a 64-bit per-device identifier, which serves as the challenge. It then shifts a 56-bit candidate response into a separate register and issues an update. If the response equals the stored key exactly, debug-enable rises and stays high until the next reset. A wrong response raises a one-cycle alarm and leaves the gate locked. Every reset locks the gate again, so the exchange must be repeated.

Top module: `dbg_auth_gate`

## Requirements
- R1: With the kill bit clear, the mode field is decoded as follows. 2'b00 gives `dbg_en` = 1 at all times. 2'b01 requires authentication, and `dbg_en` is 0 until it succeeds. 2'b10 and 2'b11 hold `dbg_en` at 0.
- R2: When `kill_fuse` is 1, `dbg_en`, `bscan_en`, `jt_tdo` and `alarm` stay 0 whatever the mode, the shift traffic or the response.
- R3: `bscan_en` is 1 whenever `kill_fuse` is 0, in every mode.
- R4: With `jt_sel_resp` = 0, a capture loads the 64-bit `challenge_id` and `jt_tdo` shows bit 0 of it. Each following shift cycle presents the next higher bit, so bit i appears on `jt_tdo` after i shifts (least significant bit first).
- R5: With `jt_sel_resp` = 1, a capture clears the response register, and each shift moves `jt_tdi` in least significant bit first, so the first bit shifted lands in bit 0 after 56 shifts. In mode 2'b01, an update compares the register with `secret_key`. An exact match drives `dbg_en` to 1 in the cycle after the update.
- R6: While `jt_sel_resp` = 1, `jt_tdo` is 0, so neither the key nor the response can be read back.
- R7: An update of the response counts as a failed comparison unless, since reset, a full 64-shift challenge read has been completed by a capture, 64 shifts and an update with `jt_sel_resp` = 0.
- R8: A failed comparison while locked gives `alarm` = 1 for exactly the one cycle after the update, and `dbg_en` stays 0.
- R9: Any reset returns an authenticated gate to the locked state (`dbg_en` = 0 in mode 2'b01).
- R10: Once unlocked, later response updates, whether correct or wrong, change nothing and raise no alarm until reset.
- R11: In modes other than 2'b01, response updates never raise `alarm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_fuse | input | 2 | Security mode field |
| kill_fuse | input | 1 | Debug kill bit, overrides mode |
| challenge_id | input | 64 | Per-device unique identifier (challenge) |
| secret_key | input | 56 | Hidden expected response |
| jt_sel_resp | input | 1 | 0 selects challenge register, 1 selects response register |
| jt_capture | input | 1 | Capture strobe for the selected register |
| jt_shift | input | 1 | Shift strobe for the selected register |
| jt_update | input | 1 | Update strobe for the selected register |
| jt_tdi | input | 1 | Serial data in |
| jt_tdo | output | 1 | Serial data out |
| dbg_en | output | 1 | Debug access enable |
| bscan_en | output | 1 | Boundary-scan enable |
| alarm | output | 1 | One-cycle pulse on a failed comparison |

## Verification
The bound assertions check the policy decode on every cycle: the kill override, the closed modes, boundary-scan availability and the silent TDO while the response register is selected. They also check that an alarm or an unlock only follows a response update, and that reset leaves the authenticated gate locked. Only the bench's scenarios can show the serial content and bit order of the challenge, the exact-match rule across every single-bit error in the key, the rule that the challenge must be read before the response is checked, and that the unlock persists and is repeated after reset.

// File: rtl/dbg_gate_pkg.sv
// Shared types for the debug access gate.
// Assumes: fused inputs are static during normal operation.
package dbg_gate_pkg;

    typedef enum logic [1:0] {
        POL_OPEN  = 2'd0,
        POL_AUTH  = 2'd1,
        POL_BLOCK = 2'd2,
        POL_KILL  = 2'd3
    } policy_e;

    // Reduce kill bit and mode field to a single access policy.
    function automatic policy_e decode_policy(input logic kill, input logic [1:0] mode);
        if (kill)               return POL_KILL;
        else if (mode == 2'b00) return POL_OPEN;
        else if (mode == 2'b01) return POL_AUTH;
        else                    return POL_BLOCK;
    endfunction

endpackage

// File: rtl/gate_policy.sv
// Policy decoder: turns the fused mode field and kill bit into a policy.
// Assumes: unused encoding 2'b10 is treated as closed.
module gate_policy
    import dbg_gate_pkg::*;
(
    input  logic       kill,
    input  logic [1:0] mode,
    output policy_e    pol
);

    // Purely combinational decode of the fuse inputs.
    always_comb pol = decode_policy(kill, mode);

endmodule

// File: rtl/chal_shifter.sv
// Challenge shift register: loads the device identifier on capture,
// shifts it out LSB first, and records a completed full-width read.
// Assumes: strobes arrive already qualified by register select and enable.
module chal_shifter #(
    parameter int CHAL_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              shift,
    input  logic              update,
    input  logic              tdi,
    input  logic [CHAL_W-1:0] id,
    output logic              tdo_bit,
    output logic              done
);

    localparam int CNT_W = $clog2(CHAL_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(CHAL_W);

    logic [CHAL_W-1:0] sr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;

    // Shift register: load on capture, move right on shift.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (capture) sr_q <= id;
        else if (shift)   sr_q <= {tdi, sr_q[CHAL_W-1:1]};
    end

    // Count bits shifted since capture, saturating at full width.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt_q <= '0;
        else if (capture)               cnt_q <= '0;
        else if (shift && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end

    // Sticky flag: a full challenge read was closed by an update.
    always_ff @(posedge clk) begin
        if (!rst_n)                        done_q <= 1'b0;
        else if (update && cnt_q == FULL)  done_q <= 1'b1;
    end

    assign tdo_bit = sr_q[0];
    assign done    = done_q;

endmodule

// File: rtl/resp_checker.sv
// Response register and comparator: collects the candidate response LSB
// first, compares it with the key on update, and holds the unlock state.
// Assumes: strobes arrive already qualified by register select and enable.
module resp_checker #(
    parameter int KEY_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             capture,
    input  logic             shift,
    input  logic             update,
    input  logic             tdi,
    input  logic             chal_done,
    input  logic [KEY_W-1:0] key,
    output logic             unlocked,
    output logic             alarm
);

    logic [KEY_W-1:0] sr_q;
    logic             unlocked_q;
    logic             alarm_q;
    logic             fire;
    logic             match;

    // Response register: clear on capture, shift in from the top.
    always_ff @(posedge clk) begin
        if (!rst_n)       sr_q <= '0;
        else if (capture) sr_q <= '0;
        else if (shift)   sr_q <= {tdi, sr_q[KEY_W-1:1]};
    end

    // A comparison happens only while armed and still locked.
    always_comb begin
        fire  = arm && update && !unlocked_q;
        match = chal_done && (sr_q == key);
    end

    // Unlock state: set on a good comparison, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)            unlocked_q <= 1'b0;
        else if (fire && match) unlocked_q <= 1'b1;
    end

    // Alarm: one-cycle pulse per failed comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) alarm_q <= 1'b0;
        else        alarm_q <= fire && !match;
    end

    assign unlocked = unlocked_q;
    assign alarm    = alarm_q;

endmodule

// File: rtl/dbg_auth_gate.sv
// Debug access gate top: decodes the fused policy, routes the JTAG shift
// strobes to the challenge or response register, and drives the enables.
// Assumes: the TAP supplies one-cycle capture/shift/update strobes.
module dbg_auth_gate
    import dbg_gate_pkg::*;
#(
    parameter int CHAL_W = 64,
    parameter int KEY_W  = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_fuse,
    input  logic              kill_fuse,
    input  logic [CHAL_W-1:0] challenge_id,
    input  logic [KEY_W-1:0]  secret_key,
    input  logic              jt_sel_resp,
    input  logic              jt_capture,
    input  logic              jt_shift,
    input  logic              jt_update,
    input  logic              jt_tdi,
    output logic              jt_tdo,
    output logic              dbg_en,
    output logic              bscan_en,
    output logic              alarm
);

    policy_e pol;
    logic    live;
    logic    c_cap, c_sh, c_up;
    logic    r_cap, r_sh, r_up;
    logic    chal_bit, chal_done, unlocked;

    gate_policy u_pol (
        .kill (kill_fuse),
        .mode (mode_fuse),
        .pol  (pol)
    );

    // Steer strobes to the selected register; kill freezes both.
    always_comb begin
        live  = (pol != POL_KILL);
        c_cap = live && !jt_sel_resp && jt_capture;
        c_sh  = live && !jt_sel_resp && jt_shift;
        c_up  = live && !jt_sel_resp && jt_update;
        r_cap = live &&  jt_sel_resp && jt_capture;
        r_sh  = live &&  jt_sel_resp && jt_shift;
        r_up  = live &&  jt_sel_resp && jt_update;
    end

    chal_shifter #(.CHAL_W(CHAL_W)) u_chal (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (c_cap),
        .shift   (c_sh),
        .update  (c_up),
        .tdi     (jt_tdi),
        .id      (challenge_id),
        .tdo_bit (chal_bit),
        .done    (chal_done)
    );

    resp_checker #(.KEY_W(KEY_W)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (pol == POL_AUTH),
        .capture   (r_cap),
        .shift     (r_sh),
        .update    (r_up),
        .tdi       (jt_tdi),
        .chal_done (chal_done),
        .key       (secret_key),
        .unlocked  (unlocked),
        .alarm     (alarm)
    );

    // Output enables and TDO mux; the response side always reads zero.
    always_comb begin
        jt_tdo   = live && !jt_sel_resp && chal_bit;
        dbg_en   = (pol == POL_OPEN) || (pol == POL_AUTH && unlocked);
        bscan_en = live;
    end

endmodule

// File: rtl/dbg_auth_gate_chk.sv
// Checker for the debug access gate, bound to every instance of the top.
// Assumes: fuse inputs do not change while an unlock is being judged.
module dbg_auth_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_fuse,
    input logic       kill_fuse,
    input logic       jt_sel_resp,
    input logic       jt_update,
    input logic       jt_tdo,
    input logic       dbg_en,
    input logic       bscan_en,
    input logic       alarm
);

    logic was_rst;

    // Remember whether the previous edge saw reset asserted.
    always_ff @(posedge clk) was_rst <= !rst_n;

    AST_KILL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        kill_fuse |-> (!dbg_en && !bscan_en && !jt_tdo && !alarm)); // R2

    AST_OPEN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!kill_fuse && mode_fuse == 2'b00) |-> dbg_en); // R1

    AST_CLOSED_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!kill_fuse && mode_fuse[1]) |-> !dbg_en); // R1

    AST_BSCAN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !kill_fuse |-> bscan_en); // R3

    AST_RESP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        jt_sel_resp |-> !jt_tdo); // R6

    AST_UNLOCK_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dbg_en) && $stable(mode_fuse) && $stable(kill_fuse)
         && mode_fuse == 2'b01 && !kill_fuse)
        |-> $past(jt_update && jt_sel_resp)); // R5

    AST_ALARM_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |-> $past(jt_update && jt_sel_resp)); // R8

    AST_ALARM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && mode_fuse == 2'b01) |-> !dbg_en); // R8

    AST_ALARM_AUTH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_fuse != 2'b01 && $stable(mode_fuse)) |-> !alarm); // R11

    AST_RESET_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (was_rst && !kill_fuse && mode_fuse == 2'b01) |-> !dbg_en); // R9

endmodule

bind dbg_auth_gate dbg_auth_gate_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_fuse   (mode_fuse),
    .kill_fuse   (kill_fuse),
    .jt_sel_resp (jt_sel_resp),
    .jt_update   (jt_update),
    .jt_tdo      (jt_tdo),
    .dbg_en      (dbg_en),
    .bscan_en    (bscan_en),
    .alarm       (alarm)
);

// File: tb/dbg_auth_gate_test.sv
// Self-checking bench for the debug access gate.
module dbg_auth_gate_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  mode_fuse;
    logic        kill_fuse;
    logic [63:0] challenge_id;
    logic [55:0] secret_key;
    logic        jt_sel_resp, jt_capture, jt_shift, jt_update, jt_tdi;
    logic        jt_tdo, dbg_en, bscan_en, alarm;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    dbg_auth_gate uut (
        .clk(clk), .rst_n(rst_n), .mode_fuse(mode_fuse), .kill_fuse(kill_fuse),
        .challenge_id(challenge_id), .secret_key(secret_key),
        .jt_sel_resp(jt_sel_resp), .jt_capture(jt_capture), .jt_shift(jt_shift),
        .jt_update(jt_update), .jt_tdi(jt_tdi), .jt_tdo(jt_tdo),
        .dbg_en(dbg_en), .bscan_en(bscan_en), .alarm(alarm)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    // Read nbits of the challenge and close with an update.
    task automatic read_chal(input int nbits, input bit exp_live);
        jt_sel_resp = 1'b0;
        jt_capture  = 1'b1;
        tick();
        jt_capture  = 1'b0;
        jt_shift    = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            jt_tdi = 1'b0;
            chk(jt_tdo == (exp_live & challenge_id[i]), "R4 challenge bit",
                64'(jt_tdo), 64'(exp_live & challenge_id[i]));
            tick();
        end
        jt_shift  = 1'b0;
        jt_update = 1'b1;
        tick();
        jt_update = 1'b0;
    endtask

    // Shift a 56-bit response LSB first, then update; returns after update edge.
    task automatic send_resp(input logic [55:0] r);
        jt_sel_resp = 1'b1;
        jt_capture  = 1'b1;
        tick();
        jt_capture  = 1'b0;
        jt_shift    = 1'b1;
        for (int i = 0; i < 56; i++) begin
            jt_tdi = r[i];
            if (i % 8 == 0)
                chk(jt_tdo == 1'b0, "R6 response tdo", 64'(jt_tdo), 64'd0);
            tick();
        end
        jt_shift  = 1'b0;
        jt_update = 1'b1;
        tick();
        jt_update = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_fuse = 2'b01; kill_fuse = 1'b0;
        challenge_id = 64'hF0E1_D2C3_B4A5_9687; secret_key = 56'hEDCBA987654321;
        jt_sel_resp = 1'b0; jt_capture = 1'b0; jt_shift = 1'b0;
        jt_update = 1'b0; jt_tdi = 1'b0;
        @(negedge clk);
        do_reset();

        // Reset state in authenticated mode.
        chk(dbg_en == 1'b0, "R9 reset dbg_en", 64'(dbg_en), 64'd0);
        chk(bscan_en == 1'b1, "R3 reset bscan_en", 64'(bscan_en), 64'd1);
        chk(alarm == 1'b0, "R8 reset alarm", 64'(alarm), 64'd0);

        // Sweep of every kill/mode combination, fresh from reset.
        for (int c = 0; c < 8; c++) begin
            kill_fuse = c[2];
            mode_fuse = c[1:0];
            do_reset();
            chk(dbg_en == (!c[2] && c[1:0] == 2'b00), "R1 R2 decode dbg_en",
                64'(dbg_en), 64'(!c[2] && c[1:0] == 2'b00));
            chk(bscan_en == !c[2], "R3 R2 bscan_en", 64'(bscan_en), 64'(!c[2]));
        end

        // Kill bit: no challenge out, correct response does nothing.
        kill_fuse = 1'b1; mode_fuse = 2'b01;
        do_reset();
        read_chal(64, 1'b0);
        send_resp(secret_key);
        chk(dbg_en == 1'b0, "R2 kill dbg_en", 64'(dbg_en), 64'd0);
        chk(alarm == 1'b0, "R2 kill alarm", 64'(alarm), 64'd0);
        kill_fuse = 1'b0;

        // Non-authenticated modes never alarm.
        for (int m = 0; m < 4; m++) begin
            if (m == 1) continue;
            mode_fuse = 2'(m);
            do_reset();
            read_chal(64, 1'b1);
            send_resp(~secret_key);
            chk(alarm == 1'b0, "R11 no alarm", 64'(alarm), 64'd0);
            chk(dbg_en == (m == 0), "R1 mode held", 64'(dbg_en), 64'(m == 0));
        end

        // Ordering: response before the challenge read fails.
        mode_fuse = 2'b01;
        do_reset();
        send_resp(secret_key);
        chk(alarm == 1'b1, "R7 no challenge alarm", 64'(alarm), 64'd1);
        chk(dbg_en == 1'b0, "R7 no challenge locked", 64'(dbg_en), 64'd0);
        read_chal(63, 1'b1);
        send_resp(secret_key);
        chk(alarm == 1'b1, "R7 short read alarm", 64'(alarm), 64'd1);
        chk(dbg_en == 1'b0, "R7 short read locked", 64'(dbg_en), 64'd0);

        // Every single-bit error in the key fails with a one-cycle alarm.
        read_chal(64, 1'b1);
        for (int b = 0; b < 56; b++) begin
            send_resp(secret_key ^ (56'd1 << b));
            chk(alarm == 1'b1, "R8 flip alarm", 64'(alarm), 64'd1);
            chk(dbg_en == 1'b0, "R8 flip locked", 64'(dbg_en), 64'd0);
            tick();
            chk(alarm == 1'b0, "R8 alarm width", 64'(alarm), 64'd0);
        end

        // Correct response unlocks; later traffic changes nothing.
        send_resp(secret_key);
        chk(dbg_en == 1'b1, "R5 unlock", 64'(dbg_en), 64'd1);
        chk(alarm == 1'b0, "R5 no alarm on match", 64'(alarm), 64'd0);
        send_resp(~secret_key);
        chk(dbg_en == 1'b1, "R10 stays open", 64'(dbg_en), 64'd1);
        chk(alarm == 1'b0, "R10 no alarm", 64'(alarm), 64'd0);

        // Reset relocks; repeat with other identifiers and keys.
        for (int k = 0; k < 3; k++) begin
            challenge_id = 64'h0123_4567_89AB_CDEF * 64'(k + 3) + 64'(k);
            secret_key   = 56'h5A5A5A_A5A5A5A5 ^ (56'h1111111 * 56'(k + 1));
            do_reset();
            chk(dbg_en == 1'b0, "R9 relock", 64'(dbg_en), 64'd0);
            read_chal(64, 1'b1);
            send_resp(secret_key);
            chk(dbg_en == 1'b1, "R5 re-auth", 64'(dbg_en), 64'd1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule